// File: doc/BRIEF.md
# Multi-Slot Custom Operation Unit with Reload Stall

This block sits beside a processor's register file and executes custom operations held in a small set of tagged slots. Every register write is mirrored into a local copy as it happens, so each resident operation is always computing from current operands and never waits for an issue before it starts. When the processor issues a custom opcode and holds it, the unit compares the opcode against all slot tags at once. On a hit it holds the stall output high until that slot's result has settled, then presents the result with a one-cycle valid pulse. On a miss it keeps the stall high, asks an external configuration agent to load the operation into a victim slot, and goes back to the hit path once the agent acknowledges.

Settling time depends on operand age. Each slot carries a settle depth, which is the number of cycles its logic needs after the latest write to any register it reads. An operation whose operands were all written long enough before the issue finishes in the issue cycle. One whose last operand arrives at or after the issue takes extra cycles. A write to an operand during a stall starts the wait again. The array datapath itself is not part of this block. Here a slot's result is the sum, modulo 2^W, of the registers selected by its operand mask, so an operation may read any number of registers.

Top module: `xop_unit`

## Requirements
- R1: After reset, stall, res_valid and rld_req are low and no slot holds a tag, so the first issue of any opcode misses.
- R2: rf_we with rf_waddr and rf_wdata updates the live copy of that register at the clock edge. A slot's result is the sum modulo 2^W of every register whose bit is set in its operand mask (bit r selects register r), with no limit on how many bits are set.
- R3: While iss_valid is high and iss_op matches no slot tag, stall is high in that cycle. rld_req rises in the next cycle carrying the opcode on rld_op, and stall stays high for as long as rld_req is high.
- R4: Victim slots are chosen in round-robin order 0, 1, 2, 3, 0, ..., and the order advances by one on each accepted reload.
- R5: rld_req, rld_op and rld_slot hold steady until rld_ack is sampled high. rld_req then drops in the next cycle, and the named slot takes the opcode as its tag together with rld_mask and rld_depth.
- R6: A hit whose slot is settled gives res_valid high and stall low in the issue cycle itself. A slot is settled when, for every register in its mask, the latest write was seen in a cycle c with the current cycle at or after c+1+depth.
- R7: A write to a masked register in cycle c makes the slot unsettled until cycle c+1+depth. The stall holds until then, and the result includes the new value.
- R8: A write to a masked register during a stall restarts the wait from that write. Writes to registers outside the mask have no effect on settling.
- R9: A reload overwrites the victim slot's previous tag, so issuing an evicted opcode misses again.
- R10: Several opcodes stay resident together, and any of them hits without a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_we | input | 1 | Register write strobe mirrored from the register file |
| rf_waddr | input | 3 | Register index written |
| rf_wdata | input | 16 | Register value written |
| iss_valid | input | 1 | Custom opcode issued; held until res_valid |
| iss_op | input | 6 | Custom opcode being issued |
| stall | output | 1 | Processor must hold the issue |
| res_valid | output | 1 | Result is presented this cycle |
| res_data | output | 16 | Result of the matching slot |
| rld_req | output | 1 | Reload request to the configuration agent |
| rld_op | output | 6 | Opcode to load |
| rld_slot | output | 2 | Victim slot index |
| rld_ack | input | 1 | Reload done; slot configuration valid this cycle |
| rld_mask | input | 8 | Operand mask of the loaded operation |
| rld_depth | input | 4 | Settle depth of the loaded operation |

## Verification
A wrong tag or a stale valid bit shows up at once as a reload when a hit was due, or a missing reload when a miss was due, along with a wrong rld_slot on the next request. A wrong operand-age count shows up only as a stall that is one or more cycles too long or too short. For that reason the bench counts the issue cycles of every operation against a value worked out from the write cycles and the depth, including writes that land mid-stall and writes to registers outside the mask. Mask and slot errors show up in res_data or rld_slot within the few cycles of the same issue.

// File: rtl/xop_unit.sv
module xop_unit #(
  parameter int W    = 16,
  parameter int NREG = 8,
  parameter int NENT = 4,
  parameter int OPW  = 6,
  parameter int DW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rf_we,
  input  logic [$clog2(NREG)-1:0] rf_waddr,
  input  logic [W-1:0]     rf_wdata,
  input  logic             iss_valid,
  input  logic [OPW-1:0]   iss_op,
  output logic             stall,
  output logic             res_valid,
  output logic [W-1:0]     res_data,
  output logic             rld_req,
  output logic [OPW-1:0]   rld_op,
  output logic [$clog2(NENT)-1:0] rld_slot,
  input  logic             rld_ack,
  input  logic [NREG-1:0]  rld_mask,
  input  logic [DW-1:0]    rld_depth
);
  localparam int RAW = $clog2(NREG);
  localparam int EW  = $clog2(NENT);
  localparam logic [DW-1:0] AMAX = {DW{1'b1}};

  logic [W-1:0]    regs    [NREG];
  logic [DW-1:0]   age     [NREG];
  logic [NENT-1:0] ent_v;
  logic [OPW-1:0]  ent_tag [NENT];
  logic [NREG-1:0] ent_mask[NENT];
  logic [DW-1:0]   ent_dep [NENT];
  logic [W-1:0]    esum    [NENT];
  logic [NENT-1:0] hit, rdy;
  logic            loading;
  logic [EW-1:0]   vptr;
  logic [OPW-1:0]  op_q;

  always_comb begin
    for (int e = 0; e < NENT; e++) begin
      hit[e]  = ent_v[e] && (ent_tag[e] == iss_op);
      rdy[e]  = 1'b1;
      esum[e] = '0;
      for (int r = 0; r < NREG; r++) begin
        if (ent_mask[e][r]) begin
          esum[e] = esum[e] + regs[r];
          if (age[r] < ent_dep[e] || (rf_we && rf_waddr == RAW'(r)))
            rdy[e] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    res_data = '0;
    for (int e = 0; e < NENT; e++)
      if (hit[e]) res_data = res_data | esum[e];
  end

  assign res_valid = iss_valid && !loading && |(hit & rdy);
  assign stall     = iss_valid && !res_valid;
  assign rld_req   = loading;
  assign rld_op    = op_q;
  assign rld_slot  = vptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        regs[r] <= '0;
        age[r]  <= AMAX;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (rf_we && rf_waddr == RAW'(r)) begin
          regs[r] <= rf_wdata;
          age[r]  <= '0;
        end else if (age[r] != AMAX) begin
          age[r] <= age[r] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v   <= '0;
      loading <= 1'b0;
      vptr    <= '0;
      op_q    <= '0;
      for (int e = 0; e < NENT; e++) begin
        ent_tag[e]  <= '0;
        ent_mask[e] <= '0;
        ent_dep[e]  <= '0;
      end
    end else if (!loading) begin
      if (iss_valid && !(|hit)) begin
        loading <= 1'b1;
        op_q    <= iss_op;
      end
    end else if (rld_ack) begin
      loading        <= 1'b0;
      ent_v[vptr]    <= 1'b1;
      ent_tag[vptr]  <= op_q;
      ent_mask[vptr] <= rld_mask;
      ent_dep[vptr]  <= rld_depth;
      vptr           <= vptr + EW'(1);
    end
  end
endmodule

// File: rtl/xop_unit_chk.sv
module xop_unit_chk #(
  parameter int OPW = 6,
  parameter int EW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           iss_valid,
  input logic           stall,
  input logic           res_valid,
  input logic           rld_req,
  input logic           rld_ack,
  input logic [OPW-1:0] rld_op,
  input logic [EW-1:0]  rld_slot
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rld_req && !rld_ack |=> rld_req && $stable(rld_op) && $stable(rld_slot)); // R5
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rld_req && rld_ack |=> !rld_req); // R5
  AST_VICTIM_RR: assert property (@(posedge clk) disable iff (!rst_n)
    rld_req && rld_ack |=> rld_slot == EW'($past(rld_slot) + 1'b1)); // R4
  AST_MISS_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rld_req) |-> $past(iss_valid && stall)); // R3
  AST_STALL_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rld_req && iss_valid |-> stall && !res_valid); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !stall && !res_valid); // R6
endmodule

bind xop_unit xop_unit_chk #(.OPW(OPW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .stall(stall),
  .res_valid(res_valid), .rld_req(rld_req), .rld_ack(rld_ack),
  .rld_op(rld_op), .rld_slot(rld_slot)
);

// File: tb/xop_unit_bench.sv
module xop_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [15:0] rf_wdata;
  logic        iss_valid;
  logic [5:0]  iss_op;
  logic        stall, res_valid, rld_req, rld_ack;
  logic [15:0] res_data;
  logic [5:0]  rld_op;
  logic [1:0]  rld_slot;
  logic [7:0]  rld_mask;
  logic [3:0]  rld_depth;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;
  logic [15:0] mreg [8];

  always #5 clk = ~clk;

  xop_unit u_xop_unit (.*);

  localparam int NV = 13;
  localparam int V_OP  [NV] = '{ 5,  9, 12,  5,  9, 12, 33, 33, 40,  5,  9, 40, 33};
  localparam int V_WA  [NV] = '{ 0,  0,  0,  0,  1,  1,  0,  1,  0,  0,  0,  1,  0};
  localparam int V_RA  [NV] = '{ 0,  0,  0,  0,  3,  4,  0,  1,  0,  0,  0,  7,  0};
  localparam int V_VA  [NV] = '{ 0,  0,  0,  0, 77, 99,  0, 500, 0,  0,  0, 4660, 0};
  localparam int V_WB  [NV] = '{ 0,  0,  0,  0,  0,  0,  0,  3,  0,  0,  0,  0,  0};
  localparam int V_VB  [NV] = '{ 0,  0,  0,  0,  0,  0,  0, 65535, 0, 0, 0,  0,  0};
  localparam int V_CYC [NV] = '{ 3,  3,  3,  1,  4,  1,  3,  7,  3,  3,  3,  2,  1};
  localparam int V_RLD [NV] = '{ 1,  1,  1,  0,  0,  0,  1,  0,  1,  1,  1,  0,  0};
  localparam int V_SLOT[NV] = '{ 0,  1,  2,  0,  0,  0,  3,  0,  0,  1,  2,  0,  0};

  function automatic logic [7:0] op_mask(input int op);
    case (op)
      5:  return 8'b0000_0111;
      9:  return 8'b0001_1000;
      12: return 8'b1110_0001;
      33: return 8'b0000_0010;
      40: return 8'b1111_1111;
      default: return 8'b0000_0100;
    endcase
  endfunction

  function automatic logic [3:0] op_depth(input int op);
    case (op)
      9:  return 4'd2;
      12: return 4'd1;
      33: return 4'd3;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [15:0] model_sum(input int op);
    logic [15:0] s = '0;
    logic [7:0] m = op_mask(op);
    for (int r = 0; r < 8; r++) if (m[r]) s = s + mreg[r];
    return s;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input int v);
    int cyc = 0, nrld = 0, slot = -1;
    logic got = 1'b0;
    logic [15:0] data = '0;
    for (int c = 1; c <= 40 && !got; c++) begin
      rf_we = 1'b0;
      if (V_WA[v] == c) begin
        rf_we = 1'b1; rf_waddr = 3'(V_RA[v]); rf_wdata = 16'(V_VA[v]);
      end else if (V_WB[v] == c) begin
        rf_we = 1'b1; rf_waddr = 3'(V_RA[v]); rf_wdata = 16'(V_VB[v]);
      end
      iss_valid = 1'b1;
      iss_op = 6'(V_OP[v]);
      #1;
      if (rld_req) begin
        nrld++;
        slot = int'(rld_slot);
        chk(rld_op == 6'(V_OP[v]), "R3 reload opcode", int'(rld_op), V_OP[v]);
        rld_ack = 1'b1;
        rld_mask = op_mask(V_OP[v]);
        rld_depth = op_depth(V_OP[v]);
      end
      if (res_valid) begin
        got = 1'b1;
        data = res_data;
        cyc = c;
      end
      @(posedge clk);
      if (rf_we) mreg[rf_waddr] = rf_wdata;
      @(negedge clk);
      rld_ack = 1'b0;
      rf_we = 1'b0;
    end
    iss_valid = 1'b0;
    chk(got && cyc == V_CYC[v], "R6/R7/R8 issue cycles", cyc, V_CYC[v]);
    chk(nrld == V_RLD[v], "R9/R10 reload count", nrld, V_RLD[v]);
    if (V_RLD[v] != 0) chk(slot == V_SLOT[v], "R4 victim slot", slot, V_SLOT[v]);
    chk(data == model_sum(V_OP[v]), "R2 result sum", int'(data), int'(model_sum(V_OP[v])));
    idle(4);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rf_we = 1'b0; rf_waddr = '0; rf_wdata = '0;
    iss_valid = 1'b0; iss_op = '0; rld_ack = 1'b0; rld_mask = '0; rld_depth = '0;
    for (int r = 0; r < 8; r++) mreg[r] = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state at the ports
    chk(!stall && !res_valid && !rld_req, "R1 reset outputs", {stall, res_valid, rld_req}, 0);
    @(negedge clk);

    for (int r = 0; r < 8; r++) begin
      rf_we = 1'b1; rf_waddr = 3'(r); rf_wdata = 16'(r * 4111 + 17);
      @(posedge clk);
      mreg[r] = rf_wdata;
      @(negedge clk);
    end
    rf_we = 1'b0;
    idle(16);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R3/R5: delayed acknowledge on a fresh miss; slot 3 is next in the order
    iss_valid = 1'b1; iss_op = 6'd50;
    #1;
    chk(stall && !rld_req, "R3 miss stalls before request", {stall, rld_req}, 2);
    @(posedge clk); @(negedge clk);
    #1;
    chk(rld_req && rld_op == 6'd50, "R3 request opcode", int'(rld_op), 50);
    chk(rld_slot == 2'd3, "R4 victim slot after wrap", int'(rld_slot), 3);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      #1;
      chk(rld_req && rld_op == 6'd50 && rld_slot == 2'd3 && stall,
          "R5 request held without ack", {rld_req, stall}, 3);
    end
    rld_ack = 1'b1; rld_mask = op_mask(50); rld_depth = op_depth(50);
    @(posedge clk); @(negedge clk);
    rld_ack = 1'b0;
    #1;
    chk(!rld_req, "R5 request drops after ack", int'(rld_req), 0);
    chk(res_valid && res_data == model_sum(50), "R5 loaded slot answers",
        int'(res_data), int'(model_sum(50)));
    @(posedge clk); @(negedge clk);
    iss_valid = 1'b0;
    idle(2);

    // R9: slot 3 held opcode 33, which is now evicted
    iss_valid = 1'b1; iss_op = 6'd33;
    #1;
    chk(stall && !res_valid, "R9 evicted opcode misses", int'(res_valid), 0);
    @(posedge clk); @(negedge clk);
    #1;
    chk(rld_req && rld_slot == 2'd0, "R9/R4 re-reload into slot 0", int'(rld_slot), 0);
    rld_ack = 1'b1; rld_mask = op_mask(33); rld_depth = op_depth(33);
    @(posedge clk); @(negedge clk);
    rld_ack = 1'b0; iss_valid = 1'b0;
    idle(2);

    // R1: reset clears all tags
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    iss_valid = 1'b1; iss_op = 6'd40;
    #1;
    chk(stall && !res_valid, "R1 tags empty after reset", int'(res_valid), 0);
    @(posedge clk); @(negedge clk);
    #1;
    chk(rld_req && rld_slot == 2'd0, "R1 reset victim slot", int'(rld_slot), 0);
    rld_ack = 1'b1; rld_mask = op_mask(40); rld_depth = op_depth(40);
    @(posedge clk); @(negedge clk);
    rld_ack = 1'b0;
    iss_valid = 1'b0;
    idle(2);

    finish_run();
  end
endmodule